// File: doc/BRIEF.md
# SDRAM Auto-Refresh Command Sequencer

This block sits inside a DDR SDRAM memory controller and drives the command sequence for one refresh. When a request is accepted, it closes any open rows with a precharge. It then issues one or two AUTO REFRESH commands. It can optionally reopen a row with ACTIVE afterwards. Every interval between meaningful commands is counted in clock cycles and filled with NOP.

The caller supplies four things with the request: the set of banks that are currently open, the number of refreshes, whether to reopen a row, and the row and bank to reopen. All of these are captured in the accepting cycle. While the sequence runs, the block reports `busy`. It pulses `done` when the sequence is complete. The precharge form follows from how many banks were open:

- No open bank: the precharge is skipped.
- One open bank: that bank alone is precharged.
- Several open banks: all banks are precharged, using the all-bank address bit.

Both minimum gaps are parameters in cycles, found by rounding the nanosecond limits up to whole clock periods. The defaults, 3 cycles for the precharge gap and 10 cycles for the refresh gap, suit a 7.5 ns clock.

Top module: `refresh_seq`

## Requirements
- R1: While `rstN` is low, `busy`, `done`, `cke` and `dataOe` are 0, `csN`, `rasN`, `casN` and `weN` are 1, and `addr` and `bankAddr` are 0.
- R2: Out of reset with no sequence running, every cycle shows `cke`=1, `csN`=0, a NOP, `addr`=0, `bankAddr`=0, `busy`=0 and `done`=0.
- R3: Command encodings on {`rasN`,`casN`,`weN`}, all with `csN`=0: NOP = 111, PRECHARGE = 010, AUTO REFRESH = 001, ACTIVE = 011. AUTO REFRESH and NOP carry `addr`=0 and `bankAddr`=0.
- R4: A request is accepted at a rising edge where `reqValid`=1 and either `busy`=0 or `done`=1. From the cycle after that edge, `busy` is 1 up to and including the `done` cycle. That first cycle is a NOP, and the first meaningful command appears in the cycle after it.
- R5: If `openBanks` was all zero at acceptance, no PRECHARGE is issued and the first command is AUTO REFRESH.
- R6: If exactly one bit of `openBanks` was set, PRECHARGE is issued with `addr` bit 10 low, all other `addr` bits 0, and `bankAddr` equal to that bit's index.
- R7: If two or more bits of `openBanks` were set, PRECHARGE is issued with `addr` bit 10 high, all other `addr` bits 0, and `bankAddr`=0.
- R8: The first AUTO REFRESH follows a PRECHARGE by exactly `TRP_CYC` cycles, with NOP in between.
- R9: With `reqDouble`=1, a second AUTO REFRESH follows the first by exactly `TRFC_CYC` cycles. With `reqDouble`=0, only one is issued.
- R10: With `reqReopen`=1, ACTIVE follows the last AUTO REFRESH by exactly `TRFC_CYC` cycles. It carries the captured `reqRow` on `addr` and `reqBank` on `bankAddr`, and `done` pulses in that same cycle.
- R11: With `reqReopen`=0, `done` pulses for one cycle exactly `TRFC_CYC` cycles after the last AUTO REFRESH. `busy` is 0 in the following cycle.
- R12: The request fields and `openBanks` are used only as captured at acceptance. Changes to them, and `reqValid` pulses while `busy`=1 and `done`=0, have no effect on the outputs.
- R13: `dataOe` is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Refresh request |
| reqDouble | input | 1 | Issue two AUTO REFRESH commands instead of one |
| reqReopen | input | 1 | Finish with ACTIVE to reopen a row |
| reqRow | input | ROW_W | Row to reopen |
| reqBank | input | BANK_W | Bank to reopen |
| openBanks | input | NUM_BANKS | One bit per bank currently holding an open row |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ROW_W | Address bus; bit 10 selects all-bank precharge |
| bankAddr | output | BANK_W | Bank address |
| dataOe | output | 1 | Data-path output enable, held off |

## Verification
The bench covers the three precharge forms, one per open-bank count.

- A wrong bank count would show up either as a PRECHARGE issued when nothing is open, or as a single-bank precharge that leaves other rows open.
- A counter that is off by one would move the AUTO REFRESH or ACTIVE one cycle early or late. Comparing every cycle against an expected trace catches this.

Each run changes the request fields and `openBanks`, and pulses `reqValid`, while the sequence is in flight. A design that samples the inputs live, or restarts on those pulses, would then put a wrong row or bank on the bus or change its timing.

The last part of each sequence is checked in all four combinations of single or double refresh with and without reopen. This would expose a `done` pulse that is late, repeated or missing.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  // Strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic latch;     // capture request fields
    logic issuePre;  // put PRECHARGE on the bus next cycle, load tRP wait
    logic issueRef;  // put AUTO REFRESH on the bus next cycle, load tRFC wait
    logic issueAct;  // put ACTIVE on the bus next cycle
    logic finish;    // raise done next cycle
  } seqStrobe_t;

  // Conditions reported back by the datapath
  typedef struct packed {
    logic needPre;   // at least one bank was open at acceptance
    logic waitDone;  // interval counter has expired
    logic moreRefs;  // a second refresh is still owed
    logic reopen;    // ACTIVE requested at the end
  } seqStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT_RP,
    ST_WAIT_RFC
  } seqState_t;

  // R3: {rasN, casN, weN} encodings, csN low
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_REF = 3'b001;
  localparam logic [2:0] CMD_ACT = 3'b011;

endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  seqStatus_t status,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        // R4: accept only from idle (also the done cycle)
        if (reqValid) begin
          strobe.latch = 1'b1;
          stateNext    = ST_START;
        end
      end
      ST_START: begin
        if (status.needPre) begin
          strobe.issuePre = 1'b1;
          stateNext       = ST_WAIT_RP;
        end else begin
          // R5: nothing open, go straight to refresh
          strobe.issueRef = 1'b1;
          stateNext       = ST_WAIT_RFC;
        end
      end
      ST_WAIT_RP: begin
        if (status.waitDone) begin
          strobe.issueRef = 1'b1;
          stateNext       = ST_WAIT_RFC;
        end
      end
      ST_WAIT_RFC: begin
        if (status.waitDone) begin
          if (status.moreRefs) begin
            strobe.issueRef = 1'b1;
          end else begin
            strobe.issueAct = status.reopen;
            strobe.finish   = 1'b1;
            stateNext       = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/refresh_dpath.sv
module refresh_dpath
  import refresh_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ROW_W       = 13,
  parameter int TRP_CYC     = 3,
  parameter int TRFC_CYC    = 10,
  parameter int ALLBANK_BIT = 10,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int MAX_WAIT   = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC,
  localparam int WAIT_W     = $clog2(MAX_WAIT + 1),
  localparam int CNT_W      = $clog2(NUM_BANKS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic                 reqDouble,
  input  logic                 reqReopen,
  input  logic [ROW_W-1:0]     reqRow,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [NUM_BANKS-1:0] openBanks,
  output seqStatus_t           status,
  output logic                 busy,
  output logic                 done,
  output logic                 cke,
  output logic                 csN,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN,
  output logic [ROW_W-1:0]     addr,
  output logic [BANK_W-1:0]    bankAddr
);

  // Captured request (R12)
  logic                 latDouble, latReopen;
  logic [ROW_W-1:0]     latRow;
  logic [BANK_W-1:0]    latBank;
  logic [NUM_BANKS-1:0] latOpen;
  logic [1:0]           refsIssued;
  logic [WAIT_W-1:0]    waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latDouble <= 1'b0;
      latReopen <= 1'b0;
      latRow    <= '0;
      latBank   <= '0;
      latOpen   <= '0;
    end else if (strobe.latch) begin
      latDouble <= reqDouble;
      latReopen <= reqReopen;
      latRow    <= reqRow;
      latBank   <= reqBank;
      latOpen   <= openBanks;
    end
  end

  // Per-bank index terms, one per bank
  logic [BANK_W-1:0] bankIdx [NUM_BANKS];
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_idx
    assign bankIdx[g] = BANK_W'(g);
  end

  // Open-bank population and lowest open index
  logic [CNT_W-1:0]  openCount;
  logic [BANK_W-1:0] firstOpen;
  always_comb begin
    openCount = '0;
    firstOpen = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (latOpen[i]) firstOpen = bankIdx[i];
      openCount = openCount + CNT_W'(latOpen[i]);
    end
  end

  logic multiOpen;
  assign multiOpen = (openCount > CNT_W'(1));

  // Refresh counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             refsIssued <= '0;
    else if (strobe.latch) refsIssued <= '0;
    else if (strobe.issueRef && refsIssued != 2'd3)
      refsIssued <= refsIssued + 2'd1;
  end

  // Interval counter (R8, R9, R10, R11)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitCnt <= '0;
    else if (strobe.issuePre) waitCnt <= WAIT_W'(TRP_CYC - 1);
    else if (strobe.issueRef) waitCnt <= WAIT_W'(TRFC_CYC - 1);
    else if (waitCnt != '0)   waitCnt <= waitCnt - WAIT_W'(1);
  end

  assign status.needPre  = (openCount != '0);
  assign status.waitDone = (waitCnt == '0);
  assign status.moreRefs = latDouble && (refsIssued == 2'd1);
  assign status.reopen   = latReopen;

  // Next command on the bus
  logic [2:0]        cmdNext;
  logic [ROW_W-1:0]  addrNext;
  logic [BANK_W-1:0] bankNext;
  always_comb begin
    cmdNext  = CMD_NOP;
    addrNext = '0;
    bankNext = '0;
    if (strobe.issuePre) begin
      cmdNext = CMD_PRE;
      if (multiOpen) addrNext[ALLBANK_BIT] = 1'b1;   // R7
      else           bankNext = firstOpen;          // R6
    end else if (strobe.issueRef) begin
      cmdNext = CMD_REF;
    end else if (strobe.issueAct) begin
      cmdNext  = CMD_ACT;                            // R10
      addrNext = latRow;
      bankNext = latBank;
    end
  end

  // Registered bus (R1, R2)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke      <= 1'b0;
      csN      <= 1'b1;
      rasN     <= 1'b1;
      casN     <= 1'b1;
      weN      <= 1'b1;
      addr     <= '0;
      bankAddr <= '0;
      done     <= 1'b0;
      busy     <= 1'b0;
    end else begin
      cke                <= 1'b1;
      csN                <= 1'b0;
      {rasN, casN, weN}  <= cmdNext;
      addr               <= addrNext;
      bankAddr           <= bankNext;
      done               <= strobe.finish;
      busy               <= strobe.latch | (busy & ~done);
    end
  end

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import refresh_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ROW_W       = 13,
  parameter int TRP_CYC     = 3,
  parameter int TRFC_CYC    = 10,
  parameter int ALLBANK_BIT = 10,
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqDouble,
  input  logic                 reqReopen,
  input  logic [ROW_W-1:0]     reqRow,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [NUM_BANKS-1:0] openBanks,
  output logic                 busy,
  output logic                 done,
  output logic                 cke,
  output logic                 csN,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN,
  output logic [ROW_W-1:0]     addr,
  output logic [BANK_W-1:0]    bankAddr,
  output logic                 dataOe
);

  seqStrobe_t strobe;
  seqStatus_t status;

  refresh_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .status   (status),
    .strobe   (strobe)
  );

  refresh_dpath #(
    .NUM_BANKS   (NUM_BANKS),
    .ROW_W       (ROW_W),
    .TRP_CYC     (TRP_CYC),
    .TRFC_CYC    (TRFC_CYC),
    .ALLBANK_BIT (ALLBANK_BIT)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqDouble (reqDouble),
    .reqReopen (reqReopen),
    .reqRow    (reqRow),
    .reqBank   (reqBank),
    .openBanks (openBanks),
    .status    (status),
    .busy      (busy),
    .done      (done),
    .cke       (cke),
    .csN       (csN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .addr      (addr),
    .bankAddr  (bankAddr)
  );

  // R13: data path stays undriven during refresh
  assign dataOe = 1'b0;

endmodule

// File: rtl/refresh_chk.sv
module refresh_chk #(
  parameter int ROW_W    = 13,
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 10,
  localparam int CNT_W   = $clog2(TRP_CYC + TRFC_CYC + 2) + 1,
  localparam int SAT     = TRP_CYC + TRFC_CYC + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic             cke,
  input logic             csN,
  input logic             rasN,
  input logic             casN,
  input logic             weN,
  input logic [ROW_W-1:0] addr
);

  logic isCmd, isPre, isRef;
  assign isCmd = !rasN;
  assign isPre = !rasN &&  casN && !weN;
  assign isRef = !rasN && !casN &&  weN;

  logic [CNT_W-1:0] sinceCmd;
  logic lastWasPre, lastWasRef;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceCmd   <= CNT_W'(SAT);
      lastWasPre <= 1'b0;
      lastWasRef <= 1'b0;
    end else if (isCmd) begin
      sinceCmd   <= CNT_W'(1);
      lastWasPre <= isPre;
      lastWasRef <= isRef;
    end else if (sinceCmd != CNT_W'(SAT)) begin
      sinceCmd <= sinceCmd + CNT_W'(1);
    end
  end

  // R2
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (rasN && casN && weN));

  // R2
  select_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cke && !csN));

  // R3
  ref_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRef |-> (addr == '0));

  // R8
  trp_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRef && lastWasPre) |-> (sinceCmd >= CNT_W'(TRP_CYC)));

  // R9
  trfc_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isCmd && lastWasRef) |-> (sinceCmd >= CNT_W'(TRFC_CYC)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  // R4
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

bind refresh_seq refresh_chk #(
  .ROW_W    (ROW_W),
  .TRP_CYC  (TRP_CYC),
  .TRFC_CYC (TRFC_CYC)
) u_refresh_chk (
  .clk  (clk),
  .rstN (rstN),
  .busy (busy),
  .done (done),
  .cke  (cke),
  .csN  (csN),
  .rasN (rasN),
  .casN (casN),
  .weN  (weN),
  .addr (addr)
);

// File: tb/tb_refresh_seq.sv
`timescale 1ns/1ps
module tb_refresh_seq;

  localparam int NB   = 4;
  localparam int RW   = 13;
  localparam int BW   = 2;
  localparam int TRP  = 3;
  localparam int TRFC = 10;

  localparam logic [2:0] NOP = 3'b111;
  localparam logic [2:0] PRE = 3'b010;
  localparam logic [2:0] REF = 3'b001;
  localparam logic [2:0] ACT = 3'b011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqDouble = 1'b0, reqReopen = 1'b0;
  logic [RW-1:0] reqRow = '0;
  logic [BW-1:0] reqBank = '0;
  logic [NB-1:0] openBanks = '0;
  logic busy, done, cke, csN, rasN, casN, weN, dataOe;
  logic [RW-1:0] addr;
  logic [BW-1:0] bankAddr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  refresh_seq #(.NUM_BANKS(NB), .ROW_W(RW), .TRP_CYC(TRP), .TRFC_CYC(TRFC)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDouble(reqDouble),
    .reqReopen(reqReopen), .reqRow(reqRow), .reqBank(reqBank),
    .openBanks(openBanks), .busy(busy), .done(done), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .addr(addr), .bankAddr(bankAddr),
    .dataOe(dataOe)
  );

  // Expected trace, indexed by cycles since the accepting edge
  logic [2:0]    eCmd  [64];
  logic [RW-1:0] eAddr [64];
  logic [BW-1:0] eBank [64];
  logic          eDone [64];
  string         eTag  [64];
  int            eEnd;

  task automatic buildExp(input bit dbl, input bit reop, input logic [RW-1:0] row,
                          input logic [BW-1:0] bank, input logic [NB-1:0] open);
    int pos;
    int cnt;
    cnt = 0;
    for (int k = 0; k < 64; k++) begin
      eCmd[k] = NOP; eAddr[k] = '0; eBank[k] = '0; eDone[k] = 1'b0; eTag[k] = "R12";
    end
    eTag[0] = "R4";
    for (int b = 0; b < NB; b++) if (open[b]) cnt++;
    pos = 1;
    if (cnt > 0) begin
      eCmd[1] = PRE;
      if (cnt > 1) begin
        eAddr[1][10] = 1'b1;
        eTag[1] = "R7";
      end else begin
        for (int b = 0; b < NB; b++) if (open[b]) eBank[1] = BW'(b);
        eTag[1] = "R6";
      end
      pos = 1 + TRP;
    end
    eCmd[pos] = REF;
    eTag[pos] = (cnt == 0) ? "R5" : "R8";
    if (dbl) begin
      pos = pos + TRFC;
      eCmd[pos] = REF;
      eTag[pos] = "R9";
    end
    eEnd = pos + TRFC;
    eDone[eEnd] = 1'b1;
    if (reop) begin
      eCmd[eEnd] = ACT; eAddr[eEnd] = row; eBank[eEnd] = bank; eTag[eEnd] = "R10";
    end else begin
      eTag[eEnd] = "R11";
    end
  endtask

  task automatic compareAt(input int k);
    logic [RW+BW+7:0] act, exp;
    act = {busy, done, cke, csN, rasN, casN, weN, addr, bankAddr, dataOe};
    exp = {(k <= eEnd), eDone[k], 1'b1, 1'b0, eCmd[k], eAddr[k], eBank[k], 1'b0};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s k=%0d actual=%h expected=%h", (dataOe !== 1'b0) ? "R13" :
               (k > eEnd) ? "R11" : eTag[k], k, act, exp);
    end
  endtask

  task automatic runReq(input bit dbl, input bit reop, input logic [RW-1:0] row,
                        input logic [BW-1:0] bank, input logic [NB-1:0] open);
    buildExp(dbl, reop, row, bank, open);
    @(negedge clk);
    reqValid = 1'b1; reqDouble = dbl; reqReopen = reop;
    reqRow = row; reqBank = bank; openBanks = open;
    for (int k = 0; k <= eEnd + 1; k++) begin
      @(negedge clk);
      compareAt(k);
      // R12: scramble inputs and pulse reqValid while running
      reqDouble = 1'($urandom);
      reqReopen = 1'($urandom);
      reqRow    = RW'($urandom);
      reqBank   = BW'($urandom);
      openBanks = NB'($urandom);
      reqValid  = (k < eEnd - 1) ? 1'($urandom) : 1'b0;
    end
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finishRun();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7341);
    // R1: reset values
    repeat (3) @(negedge clk);
    checks++;
    if ({busy, done, cke, csN, rasN, casN, weN, addr, bankAddr, dataOe} !==
        {3'b000, 4'b1111, {RW{1'b0}}, {BW{1'b0}}, 1'b0}) begin
      fails++;
      $display("FAIL R1 actual=%b%b%b%b%b%b%b expected=0001111", busy, done, cke, csN, rasN, casN, weN);
    end
    rstN = 1'b1;
    // R2: idle bus
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if ({busy, done, cke, csN, rasN, casN, weN, addr, bankAddr} !==
          {3'b001, 4'b0111, {RW{1'b0}}, {BW{1'b0}}}) begin
        fails++;
        $display("FAIL R2 actual=%b%b%b%b%b%b%b expected=0010111", busy, done, cke, csN, rasN, casN, weN);
      end
    end
    // Directed corners
    runReq(1'b0, 1'b0, RW'(0),      BW'(0), 4'b0000);  // R5
    runReq(1'b1, 1'b1, RW'(8191),   BW'(3), 4'b0000);  // R5 R9 R10
    runReq(1'b0, 1'b1, RW'(1234),   BW'(1), 4'b0001);  // R6
    runReq(1'b0, 1'b0, RW'(5),      BW'(2), 4'b1000);  // R6 R11
    runReq(1'b1, 1'b0, RW'(77),     BW'(0), 4'b0110);  // R7 R9
    runReq(1'b1, 1'b1, RW'(4095),   BW'(2), 4'b1111);  // R7 R10
    runReq(1'b0, 1'b1, RW'(1024),   BW'(3), 4'b0100);  // R6 R10 row with bit 10 set
    // Constrained random
    for (int n = 0; n < 40; n++) begin
      runReq(1'($urandom), 1'($urandom), RW'($urandom), BW'($urandom), NB'($urandom));
    end
    finishRun();
  end

endmodule